// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block produces the read data for a parallel NOR flash bank while the bank sits in query mode or in identifier mode. The surrounding controller decodes commands and decides which mode is active. It then presents each read as a byte offset, an access size, and a flag selecting identifier mode. The bank geometry is given as three static widths in bytes: the whole bank, one device as wired, and the widest mode of that device.

The responder first scales the byte offset into a per-device index. It looks the index up either in an internal query table of 82 bytes or in the identifier codes. A wide part running at byte width is handled on the narrow-mode path. The per-device answer is copied into every device slice of the bank word. A read wider than the bank is built from several bank-sized answers at consecutive indices.

The query table is filled from parameters when reset is asserted. A read is answered one clock after it is requested.

Top module: `cfi_query_responder`

## Requirements
- R1: Each of the three configuration widths must be 1, 2 or 4 bytes. The device width may not exceed either the maximum device width or the bank width.
- R2: A read accepted at a rising edge (rd_req high) raises rd_valid for exactly the next cycle, with rd_data updated at that same edge. In a cycle with no request, rd_valid falls and rd_data keeps its value.
- R3: The per-device index equals the byte offset shifted right by log2(bank) + log2(max device) − log2(device).
- R4: In query mode, an index of 0x52 or above returns zero.
- R5: The query table holds ASCII 'Q','R','Y' at indices 0x10, 0x11 and 0x12, the command set 0x0001 at 0x13–0x14 (low byte first), log2 of the device size at 0x27, and 1 at 0x2C. Indices 0x00–0x0F are zero.
- R6: When the device width differs from the maximum device width, only a device width of 1 is answered. In that case the table byte fills every byte of the maximum-width word, not zero padding. Any other narrow combination returns zero.
- R7: The low device-width bytes of the per-device answer are copied into every device-width slice of the bank word.
- R8: In identifier mode (rd_ident=1), only the low 8 bits of the index are decoded. Index 0 yields MFR_CODE, index 1 yields DEV_CODE, and every other value, including the lock-status locations 2 and 3, yields zero.
- R9: A read wider than the bank is assembled from bank-width answers. Bank slot k holds the answer for offset + k·bank, placed at byte k·bank.
- R10: Data bytes at or above the access size (1 << rd_size bytes) read as zero.
- R11: While reset is asserted, rd_valid and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also reloads the query table |
| rd_req | input | 1 | Read request for this cycle |
| rd_ident | input | 1 | 1 = identifier mode, 0 = query mode |
| rd_offset | input | ADDR_W | Byte offset of the read within the bank |
| rd_size | input | SIZE_W | log2 of the access size in bytes |
| cfg_bank_bytes | input | CFG_W | Bank width in bytes |
| cfg_dev_bytes | input | CFG_W | Device width in bytes as wired |
| cfg_dev_max_bytes | input | CFG_W | Widest mode of the device in bytes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8·BUS_BYTES | Read data, byte 0 in the low bits |

## Verification
A wrong shift amount moves every answer to a neighbouring table entry. This is visible on the first read of a known string such as the 'QRY' bytes, one cycle after the request. A broken lane copy or narrow-mode path leaves unequal bytes across device slices, which shows up on the first multi-device read. A bad assembly of wide reads shows up as bytes out of order or missing in a four-byte read, and a stale output register shows as data that changes without a request.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;

   function automatic int bytes_to_log2(input int nbytes);
      int r;
      r = 0;
      for (int i = 1; i < 8; i++)
         if ((1 << i) == nbytes) r = i;
      return r;
   endfunction

   function automatic logic [7:0] qtab_entry(input int idx,
                                             input int dev_log2,
                                             input int nblocks,
                                             input int sector_bytes,
                                             input int buf_log2);
      logic [7:0] v;
      int         blk_m1;
      blk_m1 = nblocks - 1;
      case (idx)
         16'h10:  v = 8'h51;
         16'h11:  v = 8'h52;
         16'h12:  v = 8'h59;
         16'h13:  v = 8'h01;
         16'h15:  v = 8'h31;
         16'h1B:  v = 8'h45;
         16'h1C:  v = 8'h55;
         16'h1F:  v = 8'h07;
         16'h20:  v = 8'h07;
         16'h21:  v = 8'h0A;
         16'h23:  v = 8'h04;
         16'h24:  v = 8'h04;
         16'h25:  v = 8'h04;
         16'h27:  v = 8'(dev_log2);
         16'h28:  v = 8'h02;
         16'h2A:  v = 8'(buf_log2);
         16'h2C:  v = 8'h01;
         16'h2D:  v = 8'(blk_m1);
         16'h2E:  v = 8'(blk_m1 >> 8);
         16'h2F:  v = 8'(sector_bytes >> 8);
         16'h30:  v = 8'(sector_bytes >> 16);
         16'h31:  v = 8'h50;
         16'h32:  v = 8'h52;
         16'h33:  v = 8'h49;
         16'h34:  v = 8'h31;
         16'h35:  v = 8'h30;
         16'h3F:  v = 8'h01;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/cfiq_table.sv
module cfiq_table #(
   parameter int NUM_ENTRIES  = 82,
   parameter int DEV_LOG2     = 22,
   parameter int NUM_BLOCKS   = 32,
   parameter int SECTOR_BYTES = 131072,
   parameter int BUF_LOG2     = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic [NUM_ENTRIES*8-1:0] tab_flat
);
   import cfiq_pkg::*;

   logic [7:0] entry_q [NUM_ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_ENTRIES; e++)
            entry_q[e] <= qtab_entry(e, DEV_LOG2, NUM_BLOCKS, SECTOR_BYTES, BUF_LOG2);
      end
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_flat
      assign tab_flat[e*8 +: 8] = entry_q[e];
   end

endmodule

// File: rtl/cfiq_bank_resp.sv
module cfiq_bank_resp #(
   parameter int              ADDR_W      = 16,
   parameter int              NUM_ENTRIES = 82,
   parameter int              BUS_BYTES   = 4,
   parameter int              LOG_W       = 2,
   parameter int              ID_W        = 16,
   parameter logic [ID_W-1:0] MFR_CODE    = '0,
   parameter logic [ID_W-1:0] DEV_CODE    = '0
) (
   input  logic                     ident_mode,
   input  logic [ADDR_W-1:0]        chunk_off,
   input  logic [LOG_W-1:0]         lbw,
   input  logic [LOG_W-1:0]         ldw,
   input  logic [LOG_W-1:0]         lmdw,
   input  logic [NUM_ENTRIES*8-1:0] tab_flat,
   output logic [BUS_BYTES*8-1:0]   bank_word
);
   localparam int WORD_W  = BUS_BYTES * 8;
   localparam int SHIFT_W = LOG_W + 1;

   logic [SHIFT_W-1:0] shamt;
   logic [ADDR_W-1:0]  idx;
   logic [7:0]         tab_byte;
   logic [WORD_W-1:0]  dev_resp;

   assign shamt = SHIFT_W'(lbw) + SHIFT_W'(lmdw) - SHIFT_W'(ldw);
   assign idx   = chunk_off >> shamt;

   // entries past the table end stay zero
   always_comb begin
      tab_byte = 8'h00;
      for (int e = 0; e < NUM_ENTRIES; e++)
         if (idx == ADDR_W'(e)) tab_byte = tab_flat[e*8 +: 8];
   end

   always_comb begin
      dev_resp = '0;
      if (ident_mode) begin
         case (idx[7:0])
            8'd0:    dev_resp[ID_W-1:0] = MFR_CODE;
            8'd1:    dev_resp[ID_W-1:0] = DEV_CODE;
            default: dev_resp = '0;
         endcase
      end else if (ldw == lmdw) begin
         dev_resp[7:0] = tab_byte;
      end else if (ldw == '0) begin
         for (int b = 0; b < BUS_BYTES; b++)
            if (b < (1 << lmdw)) dev_resp[b*8 +: 8] = tab_byte;
      end
   end

   for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
      logic [LOG_W:0] src;
      assign src = (LOG_W+1)'(j) & (LOG_W+1)'((1 << ldw) - 1);
      assign bank_word[j*8 +: 8] = (j < (1 << lbw)) ? dev_resp[src*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/cfi_query_responder.sv
module cfi_query_responder #(
   parameter int          BUS_BYTES    = 4,
   parameter int          ADDR_W       = 16,
   parameter int          NUM_ENTRIES  = 82,
   parameter int          DEV_LOG2     = 22,
   parameter int          NUM_BLOCKS   = 32,
   parameter int          SECTOR_BYTES = 131072,
   parameter int          BUF_LOG2     = 11,
   parameter int          ID_W         = 16,
   parameter logic [15:0] MFR_CODE     = 16'h0089,
   parameter logic [15:0] DEV_CODE     = 16'h0018,
   localparam int         WORD_W       = BUS_BYTES * 8,
   localparam int         LOG_W        = $clog2($clog2(BUS_BYTES) + 1),
   localparam int         SIZE_W       = LOG_W,
   localparam int         CFG_W        = $clog2(BUS_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              rd_ident,
   input  logic [ADDR_W-1:0] rd_offset,
   input  logic [SIZE_W-1:0] rd_size,
   input  logic [CFG_W-1:0]  cfg_bank_bytes,
   input  logic [CFG_W-1:0]  cfg_dev_bytes,
   input  logic [CFG_W-1:0]  cfg_dev_max_bytes,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data
);
   import cfiq_pkg::*;

   localparam int NUM_CHUNKS = BUS_BYTES;

   if (BUS_BYTES != 4 && BUS_BYTES != 2) begin : g_bad_bus
      $error("BUS_BYTES must be 2 or 4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (ID_W > WORD_W || ID_W > 16) begin : g_bad_id
      $error("ID_W too wide");
   end
   if (NUM_ENTRIES >= (1 << ADDR_W)) begin : g_bad_tab
      $error("NUM_ENTRIES exceeds offset range");
   end

   logic [LOG_W-1:0]         lbw, ldw, lmdw;
   logic [NUM_ENTRIES*8-1:0] tab_flat;
   logic [WORD_W-1:0]        chunk_word [NUM_CHUNKS];
   logic [WORD_W-1:0]        asm_word;

   assign lbw  = LOG_W'(bytes_to_log2(int'(cfg_bank_bytes)));
   assign ldw  = LOG_W'(bytes_to_log2(int'(cfg_dev_bytes)));
   assign lmdw = LOG_W'(bytes_to_log2(int'(cfg_dev_max_bytes)));

   cfiq_table #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .DEV_LOG2    (DEV_LOG2),
      .NUM_BLOCKS  (NUM_BLOCKS),
      .SECTOR_BYTES(SECTOR_BYTES),
      .BUF_LOG2    (BUF_LOG2)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .tab_flat(tab_flat)
   );

   for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chunk
      logic [ADDR_W-1:0] off_k;
      assign off_k = rd_offset + (ADDR_W'(k) << lbw);
      cfiq_bank_resp #(
         .ADDR_W     (ADDR_W),
         .NUM_ENTRIES(NUM_ENTRIES),
         .BUS_BYTES  (BUS_BYTES),
         .LOG_W      (LOG_W),
         .ID_W       (ID_W),
         .MFR_CODE   (MFR_CODE[ID_W-1:0]),
         .DEV_CODE   (DEV_CODE[ID_W-1:0])
      ) u_resp (
         .ident_mode(rd_ident),
         .chunk_off (off_k),
         .lbw       (lbw),
         .ldw       (ldw),
         .lmdw      (lmdw),
         .tab_flat  (tab_flat),
         .bank_word (chunk_word[k])
      );
   end

   // place bank slot k at byte k*bank, drop bytes past the access size
   always_comb begin
      asm_word = '0;
      for (int b = 0; b < BUS_BYTES; b++) begin
         if (b < (1 << rd_size))
            asm_word[b*8 +: 8] = chunk_word[b >> lbw][(b & ((1 << lbw) - 1))*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= asm_word;
      end
   end

endmodule

// File: rtl/cfiq_checker.sv
module cfiq_checker #(
   parameter int BUS_BYTES = 4,
   parameter int SIZE_W    = 2,
   parameter int CFG_W     = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rd_req,
   input logic [SIZE_W-1:0]      rd_size,
   input logic [CFG_W-1:0]       cfg_bank_bytes,
   input logic [CFG_W-1:0]       cfg_dev_bytes,
   input logic [CFG_W-1:0]       cfg_dev_max_bytes,
   input logic                   rd_valid,
   input logic [BUS_BYTES*8-1:0] rd_data
);
   function automatic logic width_ok(input logic [CFG_W-1:0] w);
      return (w == 1) || (w == 2) || (w == 4);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         assert_cfg_legal_R1: assert (width_ok(cfg_bank_bytes) && width_ok(cfg_dev_bytes) &&
                                      width_ok(cfg_dev_max_bytes) &&
                                      cfg_dev_bytes <= cfg_dev_max_bytes &&
                                      cfg_dev_bytes <= cfg_bank_bytes);
      end
   end

   assert_req_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rd_valid && $stable(rd_data)));

   assert_size_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_size) == '0) |-> rd_data[BUS_BYTES*8-1:8] == '0);

   assert_narrow_unsupported_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(cfg_dev_bytes != cfg_dev_max_bytes && cfg_dev_bytes != 1))
      |-> rd_data == '0);

   assert_lane_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(cfg_bank_bytes == 2 && cfg_dev_bytes == 1 && rd_size != '0))
      |-> rd_data[7:0] == rd_data[15:8]);

endmodule

bind cfi_query_responder cfiq_checker #(
   .BUS_BYTES(BUS_BYTES),
   .SIZE_W   (SIZE_W),
   .CFG_W    (CFG_W)
) u_cfiq_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .rd_req           (rd_req),
   .rd_size          (rd_size),
   .cfg_bank_bytes   (cfg_bank_bytes),
   .cfg_dev_bytes    (cfg_dev_bytes),
   .cfg_dev_max_bytes(cfg_dev_max_bytes),
   .rd_valid         (rd_valid),
   .rd_data          (rd_data)
);

// File: tb/test_cfi_query_responder.sv
module test_cfi_query_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req = 1'b0;
   logic        rd_ident = 1'b0;
   logic [15:0] rd_offset = '0;
   logic [1:0]  rd_size = '0;
   logic [2:0]  cfg_bank_bytes = 3'd1;
   logic [2:0]  cfg_dev_bytes = 3'd1;
   logic [2:0]  cfg_dev_max_bytes = 3'd1;
   logic        rd_valid;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] got;

   always #4 clk = ~clk;

   cfi_query_responder i_cfi_query_responder (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ident(rd_ident),
      .rd_offset(rd_offset), .rd_size(rd_size),
      .cfg_bank_bytes(cfg_bank_bytes), .cfg_dev_bytes(cfg_dev_bytes),
      .cfg_dev_max_bytes(cfg_dev_max_bytes),
      .rd_valid(rd_valid), .rd_data(rd_data));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int bw, input int dw, input int mdw);
      @(negedge clk);
      cfg_bank_bytes    = 3'(bw);
      cfg_dev_bytes     = 3'(dw);
      cfg_dev_max_bytes = 3'(mdw);
   endtask

   task automatic do_read(input logic ident, input logic [15:0] off, input logic [1:0] sz);
      @(negedge clk);
      rd_ident  = ident;
      rd_offset = off;
      rd_size   = sz;
      rd_req    = 1'b1;
      @(posedge clk);
      #2;
      checks++;
      if (rd_valid !== 1'b1) begin
         errors++;
         $display("FAIL R2 valid actual=%b expected=1", rd_valid);
      end
      got = rd_data;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic t_reset;
      check("R11 valid", {31'd0, rd_valid}, 32'd0);
      check("R11 data", rd_data, 32'd0);
   endtask

   task automatic t_basic_query;
      set_cfg(1, 1, 1);
      do_read(1'b0, 16'h0010, 2'd0); check("R3 R5 x8 Q", got, 32'h51);
      do_read(1'b0, 16'h0027, 2'd0); check("R5 size log2", got, 32'h16);
      do_read(1'b0, 16'h002C, 2'd0); check("R5 region count", got, 32'h01);
      do_read(1'b0, 16'h0005, 2'd0); check("R5 low zero", got, 32'h00);
      set_cfg(2, 2, 2);
      do_read(1'b0, 16'h0022, 2'd1); check("R3 x16 R", got, 32'h0052);
   endtask

   task automatic t_bounds;
      set_cfg(1, 1, 1);
      do_read(1'b0, 16'h0052, 2'd0); check("R4 index 0x52", got, 32'h0);
      do_read(1'b0, 16'h0060, 2'd0); check("R4 index 0x60", got, 32'h0);
   endtask

   task automatic t_lanes_narrow;
      set_cfg(4, 2, 2);
      do_read(1'b0, 16'h0048, 2'd2); check("R7 two x16 lanes", got, 32'h0059_0059);
      set_cfg(2, 1, 2);
      do_read(1'b0, 16'h0040, 2'd1); check("R6 x8 of x16", got, 32'h5151);
      set_cfg(4, 2, 4);
      do_read(1'b0, 16'h0080, 2'd2); check("R6 unsupported narrow", got, 32'h0);
   endtask

   task automatic t_ident;
      set_cfg(2, 2, 2);
      do_read(1'b1, 16'h0000, 2'd1); check("R8 manufacturer", got, 32'h0089);
      do_read(1'b1, 16'h0002, 2'd1); check("R8 device", got, 32'h0018);
      do_read(1'b1, 16'h0004, 2'd1); check("R8 lock location", got, 32'h0);
      do_read(1'b1, 16'h0200, 2'd1); check("R8 low 8 bits only", got, 32'h0089);
      set_cfg(4, 1, 1);
      do_read(1'b1, 16'h0004, 2'd2); check("R7 R8 four x8", got, 32'h1818_1818);
   endtask

   task automatic t_wide_and_mask;
      set_cfg(1, 1, 1);
      do_read(1'b0, 16'h0010, 2'd2); check("R9 x8 bank 4 bytes", got, 32'h0159_5251);
      set_cfg(2, 2, 2);
      do_read(1'b0, 16'h0020, 2'd2); check("R9 x16 bank 4 bytes", got, 32'h0052_0051);
      set_cfg(4, 1, 1);
      do_read(1'b1, 16'h0000, 2'd0); check("R10 one byte", got, 32'h0000_0089);
   endtask

   task automatic t_hold;
      logic [31:0] keep;
      keep = got;
      @(posedge clk); #2;
      check("R2 valid drops", {31'd0, rd_valid}, 32'd0);
      @(negedge clk); rd_offset = 16'h0011;
      @(posedge clk); #2;
      check("R2 data held", rd_data, keep);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_basic_query();
      t_bounds();
      t_lanes_narrow();
      t_ident();
      t_wide_and_mask();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule